// File: doc/BRIEF.md
# I2C SCL Bit-Rate Generator

This block produces the SCL waveform timing for an I2C master. A system clock is divided by a power of two chosen through a 3-bit prescale field. Two 5-bit period registers set the low phase and the high phase of SCL. Each phase lasts its register value plus a fixed overhead, counted in prescaled ticks. The overhead is 4 ticks when the prescaler is bypassed (prescale 0) and 3 ticks for every other setting. It stands for the cycles spent in the line synchroniser and the noise filter.

While `run` is high, the block pulls SCL low for the low phase and then releases the line. It waits until the conditioned SCL input is seen high, and only then counts the high phase. A slave that holds SCL low therefore stretches the high phase for as long as it holds the line. The SCL input passes through a two-flop synchroniser and a tick-rate filter, so a short glitch cannot start the high phase. Single-cycle strobes mark the start of each low phase and each high phase for the byte engine.

Software programs the block through a small byte-wide register port. Address 0 is the mode register, address 1 the low period and address 2 the high period.

Top module: `scl_rate_gen`

## Requirements
- R1: In reset and at the first cycle after it, `scl_drive_low`, `low_start` and `high_start` are 0. The registers read back as mode 0x00, low period 0xFF and high period 0xFF.
- R2: Reads are combinational on `reg_addr`. The period registers read as {3'b111, 5-bit value}, and only bits 4:0 of a written byte are stored. Mode reads the prescale in bits 6:4 and zeros elsewhere. Address 3 reads 0x00.
- R3: A mode write updates the prescale from bits 6:4 only when bit 3 (write enable) of the written byte is 1. Otherwise the prescale is unchanged.
- R4: Writing a period whose low 5 bits are 0 stores 1.
- R5: Each low phase (`scl_drive_low` high) lasts exactly (low + V) × 2^n clocks, where n is the prescale and V is 4 when n = 0 and 3 otherwise.
- R6: From a `high_start` pulse to the next `low_start` pulse is exactly (high + V) × 2^n clocks.
- R7: With n = 0, after the SCL input rises while the line is released, `high_start` appears at the fifth rising clock edge and not before.
- R8: While the SCL input is held low after release, the block neither drives low nor pulses `high_start`.
- R9: With n = 0, an SCL input high pulse lasting one clock does not start the high phase. A later sustained high does.
- R10: When `run` is 0 at a rising edge, SCL is released and no strobe follows. When `run` rises, `scl_drive_low` and `low_start` are 1 after the next edge.
- R11: `low_start` is a one-clock pulse that coincides exactly with each rising edge of `scl_drive_low`, and it is never high together with `high_start`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 mode, 1 low, 2 high) |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| run | input | 1 | Generate SCL while high |
| scl_in | input | 1 | SCL line level as seen at the pad |
| scl_drive_low | output | 1 | 1 pulls SCL low, 0 releases it |
| low_start | output | 1 | Pulse at the start of each low phase |
| high_start | output | 1 | Pulse when the high phase count begins |

## Verification
Register effects appear on `reg_rdata` one clock after the write strobe. `scl_drive_low` and `low_start` follow a rise of `run` after a single edge. `high_start` trails a rising SCL input by five edges at prescale 0, which is two synchroniser stages, two filter samples and the phase register. The phase lengths are whole multiples of 2^n clocks, measured edge to edge. The bench drives inputs on falling edges and samples 1 ns after each rising edge. A behavioural monitor counts clocks between output transitions on every cycle and compares each completed phase with the length computed from the written configuration.

// File: rtl/scl_rate_pkg.sv
package scl_rate_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOW  = 2'd1,
        PH_WAIT = 2'd2,
        PH_HIGH = 2'd3
    } phase_e;

    localparam logic [1:0] ADDR_MODE = 2'd0;
    localparam logic [1:0] ADDR_LOW  = 2'd1;
    localparam logic [1:0] ADDR_HIGH = 2'd2;

endpackage

// File: rtl/scl_rate_regs.sv
module scl_rate_regs
    import scl_rate_pkg::*;
#(
    parameter int PER_W  = 5,
    parameter int PSC_W  = 3,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic [PSC_W-1:0]  psc,
    output logic [PER_W-1:0]  low_per,
    output logic [PER_W-1:0]  high_per
);
    localparam int PSC_LSB = 4;
    localparam int WP_BIT  = 3;
    localparam logic [PER_W-1:0] PER_MIN = PER_W'(1);

    typedef struct packed {
        logic [PSC_W-1:0] psc;
        logic [PER_W-1:0] low;
        logic [PER_W-1:0] high;
    } regs_t;

    regs_t r_d, r_q;
    logic  unused_wdata;

    function automatic logic [PER_W-1:0] clamp_per(input logic [PER_W-1:0] v);
        return (v == '0) ? PER_MIN : v;
    endfunction

    always_comb begin
        r_d = r_q;
        if (wr_en) begin
            unique case (addr)
                ADDR_MODE: if (wdata[WP_BIT]) r_d.psc = wdata[PSC_LSB +: PSC_W];
                ADDR_LOW:  r_d.low  = clamp_per(wdata[PER_W-1:0]);
                ADDR_HIGH: r_d.high = clamp_per(wdata[PER_W-1:0]);
                default:   ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.psc  <= '0;
            r_q.low  <= '1;
            r_q.high <= '1;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        rdata = '0;
        unique case (addr)
            ADDR_MODE: rdata[PSC_LSB +: PSC_W] = r_q.psc;
            ADDR_LOW:  rdata = {{(DATA_W-PER_W){1'b1}}, r_q.low};
            ADDR_HIGH: rdata = {{(DATA_W-PER_W){1'b1}}, r_q.high};
            default:   rdata = '0;
        endcase
    end

    assign psc          = r_q.psc;
    assign low_per      = r_q.low;
    assign high_per     = r_q.high;
    assign unused_wdata = ^wdata;

    // R3: prescale is protected unless the enable bit accompanies the write
    p_wp_guard_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_MODE && !wdata[WP_BIT]) |=> $stable(r_q.psc));

    // R4: a zero period is stored as the minimum legal value
    p_zero_clamp_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == ADDR_LOW && wdata[PER_W-1:0] == '0) |=> (r_q.low == PER_MIN));

endmodule

// File: rtl/scl_prescaler.sv
module scl_prescaler #(
    parameter int PSC_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [PSC_W-1:0] psc,
    output logic             tick
);
    localparam int CNT_W = (1 << PSC_W) - 1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } pre_t;

    pre_t             p_d, p_q;
    logic [CNT_W-1:0] mask;

    always_comb begin
        mask = (CNT_W'(1) << psc) - CNT_W'(1);
        tick = ((p_q.cnt & mask) == mask);
        p_d  = p_q;
        if (clr) p_d.cnt = '0;
        else     p_d.cnt = p_q.cnt + CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    // R5: with division active, ticks are never back to back
    p_tick_spacing_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && psc != '0 && !clr) |=> (!tick || psc == '0));

endmodule

// File: rtl/scl_input_cond.sv
module scl_input_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic scl_in,
    output logic scl_filt
);
    typedef struct packed {
        logic s1;
        logic s2;
        logic samp;
        logic filt;
    } cond_t;

    cond_t c_d, c_q;

    always_comb begin
        c_d    = c_q;
        c_d.s1 = scl_in;
        c_d.s2 = c_q.s1;
        if (tick) begin
            c_d.samp = c_q.s2;
            if (c_q.s2 == c_q.samp) c_d.filt = c_q.s2;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) c_q <= '1;
        else        c_q <= c_d;
    end

    assign scl_filt = c_q.filt;

    // R9: the filtered level only moves on a prescaled tick
    p_filter_on_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(c_q.filt));

endmodule

// File: rtl/scl_phase_fsm.sv
module scl_phase_fsm
    import scl_rate_pkg::*;
#(
    parameter int PER_W      = 5,
    parameter int PSC_W      = 3,
    parameter int OVH_BYPASS = 4,
    parameter int OVH_DIV    = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic             scl_high,
    input  logic [PSC_W-1:0] psc,
    input  logic [PER_W-1:0] low_per,
    input  logic [PER_W-1:0] high_per,
    output logic             drive_low,
    output logic             low_start,
    output logic             high_start,
    output logic             pre_clr
);
    localparam int CNT_W = PER_W + 2;

    typedef struct packed {
        phase_e           ph;
        logic [CNT_W-1:0] cnt;
        logic             ls;
        logic             hs;
    } fsm_t;

    fsm_t             f_d, f_q;
    logic [CNT_W-1:0] ovh;
    logic [CNT_W-1:0] low_load;
    logic [CNT_W-1:0] high_load;

    always_comb begin
        ovh       = (psc == '0) ? CNT_W'(OVH_BYPASS) : CNT_W'(OVH_DIV);
        low_load  = CNT_W'(low_per) + ovh - CNT_W'(1);
        high_load = CNT_W'(high_per) + ovh - CNT_W'(1);

        f_d    = f_q;
        f_d.ls = 1'b0;
        f_d.hs = 1'b0;
        if (!run) begin
            f_d.ph  = PH_IDLE;
            f_d.cnt = '0;
        end else begin
            unique case (f_q.ph)
                PH_IDLE: begin
                    f_d.ph  = PH_LOW;
                    f_d.cnt = low_load;
                    f_d.ls  = 1'b1;
                end
                PH_LOW: if (tick) begin
                    if (f_q.cnt == '0) f_d.ph = PH_WAIT;
                    else               f_d.cnt = f_q.cnt - CNT_W'(1);
                end
                PH_WAIT: if (tick && scl_high) begin
                    f_d.ph  = PH_HIGH;
                    f_d.cnt = high_load;
                    f_d.hs  = 1'b1;
                end
                PH_HIGH: if (tick) begin
                    if (f_q.cnt == '0) begin
                        f_d.ph  = PH_LOW;
                        f_d.cnt = low_load;
                        f_d.ls  = 1'b1;
                    end else begin
                        f_d.cnt = f_q.cnt - CNT_W'(1);
                    end
                end
                default: f_d.ph = PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f_q.ph  <= PH_IDLE;
            f_q.cnt <= '0;
            f_q.ls  <= 1'b0;
            f_q.hs  <= 1'b0;
        end else begin
            f_q <= f_d;
        end
    end

    assign drive_low  = (f_q.ph == PH_LOW);
    assign low_start  = f_q.ls;
    assign high_start = f_q.hs;
    assign pre_clr    = (f_q.ph == PH_IDLE);

    // R5: the last low tick releases the line
    p_low_exit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (run && f_q.ph == PH_LOW && tick && f_q.cnt == '0) |=> !drive_low);

    // R6: the high count only begins after the line was seen high
    p_high_entry_r6: assert property (@(posedge clk) disable iff (!rst_n)
        high_start |-> $past(scl_high));

    // R8: a held-low line keeps the block waiting
    p_stretch_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (run && f_q.ph == PH_WAIT && !scl_high) |=> (!drive_low && !high_start));

    // R10: stopping releases the line with no strobe
    p_stop_release_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (!drive_low && !low_start && !high_start));

    // R11: strobes are exclusive and low_start marks a driven line
    p_strobe_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        low_start |-> (drive_low && !high_start));

endmodule

// File: rtl/scl_rate_gen.sv
module scl_rate_gen #(
    parameter int PER_W      = 5,
    parameter int PSC_W      = 3,
    parameter int DATA_W     = 8,
    parameter int OVH_BYPASS = 4,
    parameter int OVH_DIV    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [1:0]        reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              run,
    input  logic              scl_in,
    output logic              scl_drive_low,
    output logic              low_start,
    output logic              high_start
);
    logic [PSC_W-1:0] psc;
    logic [PER_W-1:0] low_per;
    logic [PER_W-1:0] high_per;
    logic             tick;
    logic             pre_clr;
    logic             scl_filt;

    scl_rate_regs #(.PER_W(PER_W), .PSC_W(PSC_W), .DATA_W(DATA_W)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_wr),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .rdata    (reg_rdata),
        .psc      (psc),
        .low_per  (low_per),
        .high_per (high_per)
    );

    scl_prescaler #(.PSC_W(PSC_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (pre_clr),
        .psc   (psc),
        .tick  (tick)
    );

    scl_input_cond u_cond (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .scl_in   (scl_in),
        .scl_filt (scl_filt)
    );

    scl_phase_fsm #(
        .PER_W(PER_W), .PSC_W(PSC_W), .OVH_BYPASS(OVH_BYPASS), .OVH_DIV(OVH_DIV)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (run),
        .tick       (tick),
        .scl_high   (scl_filt),
        .psc        (psc),
        .low_per    (low_per),
        .high_per   (high_per),
        .drive_low  (scl_drive_low),
        .low_start  (low_start),
        .high_start (high_start),
        .pre_clr    (pre_clr)
    );

endmodule

// File: tb/scl_rate_gen_bench.sv
`timescale 1ns/1ps
module scl_rate_gen_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       run = 1'b0;
    logic       hold = 1'b0;
    logic       scl_in;
    logic       scl_drive_low, low_start, high_start;

    int  n_chk = 0, n_fail = 0;
    int  cfg_n = 0, cfg_low = 31, cfg_high = 31;
    bit  mon_en = 1'b0;
    bit  prev_dl = 1'b0;
    bit  hi_armed = 1'b0;
    int  low_len = 0, hi_len = 0;
    bit  finished = 1'b0;

    always #2 clk = ~clk;

    // open-drain line: the block or a slave can pull it low
    assign scl_in = ~scl_drive_low & ~hold;

    scl_rate_gen u_scl_rate_gen (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .run(run), .scl_in(scl_in),
        .scl_drive_low(scl_drive_low), .low_start(low_start), .high_start(high_start)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int ovh_of(input int n);
        return (n == 0) ? 4 : 3;
    endfunction

    function automatic int exp_low();
        return (cfg_low + ovh_of(cfg_n)) << cfg_n;
    endfunction

    function automatic int exp_high();
        return (cfg_high + ovh_of(cfg_n)) << cfg_n;
    endfunction

    // behavioural reference: measures every phase on every clock
    always @(posedge clk) begin
        #1;
        if (rst_n && mon_en) begin
            if (run)
                chk(low_start == (scl_drive_low && !prev_dl), "R11 low_start pulse",
                    int'(low_start), int'(scl_drive_low && !prev_dl));
            if (scl_drive_low && !prev_dl) low_len = 1;
            else if (scl_drive_low)        low_len++;
            if (!scl_drive_low && prev_dl && run)
                chk(low_len == exp_low(), "R5 low phase length", low_len, exp_low());
            if (hi_armed) hi_len++;
            if (low_start && hi_armed && run)
                chk(hi_len == exp_high(), "R6 high phase length", hi_len, exp_high());
            if (low_start) hi_armed = 1'b0;
            if (high_start) begin
                hi_armed = 1'b1;
                hi_len   = 0;
            end
            if (!run) hi_armed = 1'b0;
        end
        prev_dl = scl_drive_low;
    end

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_chk(input logic [1:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk);
        reg_addr = a;
        #1;
        chk(reg_rdata == exp, tag, int'(reg_rdata), int'(exp));
    endtask

    task automatic set_cfg(input int n, input int l, input int h);
        wr(2'd0, 8'((n << 4) | 8));
        wr(2'd1, 8'(l));
        wr(2'd2, 8'(h));
        cfg_n = n; cfg_low = l; cfg_high = h;
    endtask

    task automatic sample();
        @(posedge clk);
        #1;
    endtask

    task automatic wait_ls(input int cnt, input string tag);
        int seen = 0;
        for (int i = 0; i < 6000 && seen < cnt; i++) begin
            sample();
            if (low_start) seen++;
        end
        chk(seen == cnt, tag, seen, cnt);
    endtask

    task automatic wait_release();
        bit was_low = 1'b0;
        bit done = 1'b0;
        for (int i = 0; i < 6000 && !done; i++) begin
            sample();
            if (scl_drive_low) was_low = 1'b1;
            else if (was_low)  done = 1'b1;
        end
        chk(done, "R5 line released after low phase", int'(done), 1);
    endtask

    task automatic run_cfg(input int n, input int l, input int h);
        set_cfg(n, l, h);
        @(negedge clk) run = 1'b1;
        wait_ls(4, "R6 phases repeat");
        @(negedge clk) run = 1'b0;
        sample();
    endtask

    initial begin
        repeat (3) sample();
        chk(!scl_drive_low && !low_start && !high_start, "R1 outputs in reset",
            int'({scl_drive_low, low_start, high_start}), 0);
        @(negedge clk) rst_n = 1'b1;
        sample();
        chk(!scl_drive_low && !low_start && !high_start, "R1 outputs after reset",
            int'({scl_drive_low, low_start, high_start}), 0);
        rd_chk(2'd0, 8'h00, "R1 mode reset value");
        rd_chk(2'd1, 8'hFF, "R1 low period reset value");
        rd_chk(2'd2, 8'hFF, "R1 high period reset value");
        rd_chk(2'd3, 8'h00, "R2 unmapped address");
        wr(2'd1, 8'h25); rd_chk(2'd1, 8'hE5, "R2 low period keeps 5 bits");
        wr(2'd2, 8'h03); rd_chk(2'd2, 8'hE3, "R2 high period readback");
        wr(2'd0, 8'h50); rd_chk(2'd0, 8'h00, "R3 mode write without enable ignored");
        wr(2'd0, 8'h58); rd_chk(2'd0, 8'h50, "R3 mode write with enable");
        wr(2'd1, 8'h00); rd_chk(2'd1, 8'hE1, "R4 zero low period clamps");
        wr(2'd2, 8'hE0); rd_chk(2'd2, 8'hE1, "R4 zero high period clamps");

        mon_en = 1'b1;
        run_cfg(0, 5, 3);
        run_cfg(3, 1, 2);
        run_cfg(1, 31, 31);
        run_cfg(7, 2, 1);

        // R7 / R9 at prescale 0
        set_cfg(0, 5, 3);
        @(negedge clk) begin hold = 1'b1; run = 1'b1; end
        wait_release();
        for (int i = 0; i < 3; i++) begin
            sample();
            chk(!scl_drive_low && !high_start, "R8 waiting while held", int'(high_start), 0);
        end
        @(negedge clk) hold = 1'b0;
        for (int k = 1; k <= 5; k++) begin
            sample();
            chk(high_start == (k == 5), "R7 high_start latency", int'(high_start), int'(k == 5));
        end
        wait_ls(1, "R7 next low phase");
        @(negedge clk) hold = 1'b1;
        wait_release();
        repeat (3) sample();
        @(negedge clk) hold = 1'b0;
        @(negedge clk) hold = 1'b1;
        for (int i = 0; i < 12; i++) begin
            sample();
            chk(!high_start && !scl_drive_low, "R9 one-clock glitch rejected",
                int'({high_start, scl_drive_low}), 0);
        end
        @(negedge clk) hold = 1'b0;
        begin
            bit got = 1'b0;
            for (int i = 0; i < 10 && !got; i++) begin
                sample();
                if (high_start) got = 1'b1;
            end
            chk(got, "R9 sustained high accepted", int'(got), 1);
        end
        wait_ls(2, "R9 phases resume");
        @(negedge clk) run = 1'b0;
        sample();

        // R8 stretching at prescale 2
        set_cfg(2, 3, 4);
        @(negedge clk) begin hold = 1'b1; run = 1'b1; end
        wait_release();
        for (int i = 0; i < 40; i++) begin
            sample();
            chk(!scl_drive_low && !high_start, "R8 stretch holds block",
                int'({scl_drive_low, high_start}), 0);
        end
        @(negedge clk) hold = 1'b0;
        wait_ls(2, "R8 phases resume after stretch");
        @(negedge clk) run = 1'b0;
        sample();

        // R10 stop and restart
        set_cfg(3, 4, 4);
        @(negedge clk) run = 1'b1;
        sample();
        chk(scl_drive_low && low_start, "R10 start drives low", int'({scl_drive_low, low_start}), 3);
        repeat (5) sample();
        @(negedge clk) run = 1'b0;
        sample();
        chk(!scl_drive_low, "R10 stop releases", int'(scl_drive_low), 0);
        for (int i = 0; i < 10; i++) begin
            sample();
            chk(!scl_drive_low && !low_start && !high_start, "R10 idle quiet",
                int'({scl_drive_low, low_start, high_start}), 0);
        end
        @(negedge clk) run = 1'b1;
        sample();
        chk(scl_drive_low && low_start, "R10 restart drives low", int'({scl_drive_low, low_start}), 3);
        wait_ls(2, "R10 phases after restart");
        @(negedge clk) run = 1'b0;
        repeat (4) sample();

        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #(200000 * 4);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule